// File: doc/BRIEF.md
# ADC Conversion Control Sequencer

This block is the digital front end of a successive-approximation converter. A CPU writes one byte-wide mode register that holds a comparator enable, a run bit, a single-channel/scan selector and a conversion-time code. The code is passed straight out to the converter core. Writes use one protocol for two forms: the whole byte, or one bit chosen by index.

Once the comparator is enabled, a settle counter measures its warm-up time. The sequencer then issues one-cycle start pulses to an external converter core and waits for a done pulse before it reports each result. Every result leaves with a valid strobe, its channel number and a discard flag. The flag marks the first result of a run as untrustworthy when the run began before the comparator had settled.

There are three trigger modes. Software mode converts back to back while the run bit is set. Hardware wait mode waits for a trigger, then for settling, then converts once. Hardware no-wait mode converts once per trigger at once. The run bit read back reports status in a way that depends on the trigger mode.

Top module: `adc_seq_ctrl`

## Requirements
- R1: After reset, rd_data reads 0x00, cmp_ready is 0, and no conv_start or res_valid pulse occurs while no run is set.
- R2: A write with wr_bit=0 replaces the whole register with wr_data. A write with wr_bit=1 changes only bit wr_idx to wr_val. Bits 6:0 read back as stored. Layout: bit 7 run, bits 6:2 conversion-time code (driven on ctime_sel), bit 1 scan (1) or single (0), bit 0 comparator enable.
- R3: cmp_ready rises exactly SETTLE_CYC = CYC_PER_US*SETTLE_US cycles after the write edge that sets bit 0. It drops in the cycle after bit 0 is cleared.
- R4: In software and no-wait modes, the first result after the run bit goes 0 to 1 has res_discard=1 if that write came less than SETTLE_CYC cycles after the enable write. Otherwise the first result has res_discard=0. All later results of the run have res_discard=0.
- R5: With trig_mode 00 or 11 (software) and the run bit set, conversions repeat. Each conv_start answered by conv_done produces one res_valid with the channel that was started.
- R6: In single mode every conversion uses the base channel loaded through base_wr.
- R7: In scan mode the channels are base, base+1, base+2 and base+3 (modulo 2^CH_W), then the sequence wraps. Each new run restarts at base.
- R8: In software mode bit 7 reads 1 while a run is active. It reads 0 from the second cycle after the stop write.
- R9: With trig_mode 01 (hardware wait), the run bit alone starts nothing and bit 7 reads 0 in standby. Each hw_trig restarts the settle count. conv_start appears SETTLE_CYC+2 cycles after the trigger cycle. Bit 7 reads 1 from the trigger until the result, and all results have res_discard=0.
- R10: With trig_mode 10 (hardware no-wait), hw_trig produces conv_start in the following cycle, and bit 7 reads back the written value.
- R11: Writing 0 to the run bit aborts any conversion. A conv_done still in flight produces no result, and no conv_start follows.
- R12: conv_start is a one-cycle pulse, and no new one is issued until the previous conversion is done.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| wr_bit | input | 1 | 1 = single-bit write, 0 = byte write |
| wr_idx | input | 3 | Bit index for single-bit write |
| wr_val | input | 1 | Bit value for single-bit write |
| wr_data | input | 8 | Byte for byte write |
| rd_data | output | 8 | Register read value with mode-dependent status in bit 7 |
| base_wr | input | 1 | Load base channel |
| base_data | input | CH_W | Base channel value |
| trig_mode | input | 2 | 00/11 software, 01 hardware wait, 10 hardware no-wait |
| hw_trig | input | 1 | Hardware trigger pulse |
| cmp_ready | output | 1 | Comparator settled |
| ctime_sel | output | 5 | Conversion-time code |
| conv_start | output | 1 | Start pulse to converter core |
| conv_ch | output | CH_W | Channel of the conversion being started |
| conv_done | input | 1 | Done pulse from converter core |
| res_valid | output | 1 | Result strobe |
| res_discard | output | 1 | Result must be thrown away |
| res_ch | output | CH_W | Channel of the result |

## Verification
The assertions assume the converter core raises conv_done only while a conversion is outstanding, and never in the same cycle as conv_start. The bench's core model meets this by answering each start a fixed four cycles later. The assertions also assume trig_mode and base channel are only changed while the run bit is 0. The stimulus keeps to this by switching modes only between runs, after the stop write has taken effect.

// File: rtl/adc_seq_pkg.sv
`timescale 1ns/1ps
package adc_seq_pkg;
  typedef enum logic [1:0] {
    TRIG_SW        = 2'b00,
    TRIG_HW_WAIT   = 2'b01,
    TRIG_HW_NOWAIT = 2'b10,
    TRIG_SW_ALT    = 2'b11
  } trig_mode_e;

  typedef enum logic [1:0] {
    ENG_IDLE = 2'b00,
    ENG_STAB = 2'b01,
    ENG_BUSY = 2'b10
  } eng_state_e;

  localparam int MODE_W     = 8;
  localparam int BIT_RUN    = 7;
  localparam int CTIME_HI   = 6;
  localparam int CTIME_LO   = 2;
  localparam int BIT_SCAN   = 1;
  localparam int BIT_CMP_EN = 0;
endpackage

// File: rtl/adc_mode_reg.sv
`timescale 1ns/1ps
module adc_mode_reg #(
  parameter int REG_W = 8,
  localparam int IW = $clog2(REG_W)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             wr_en,
  input  logic             wr_bit,
  input  logic [IW-1:0]    wr_idx,
  input  logic             wr_val,
  input  logic [REG_W-1:0] wr_data,
  output logic [REG_W-1:0] mode_q
);
  for (genvar b = 0; b < REG_W; b++) begin : g_bit
    always_ff @(posedge clk) begin
      if (rst)
        mode_q[b] <= 1'b0;
      else if (wr_en && !wr_bit)
        mode_q[b] <= wr_data[b];
      else if (wr_en && wr_bit && (wr_idx == IW'(b)))
        mode_q[b] <= wr_val;
    end
  end
endmodule

// File: rtl/adc_settle_timer.sv
`timescale 1ns/1ps
module adc_settle_timer #(
  parameter int SETTLE_CYC = 8,
  localparam int CW = $clog2(SETTLE_CYC + 1)
) (
  input  logic clk,
  input  logic rst,
  input  logic en,
  input  logic reload,
  output logic settled
);
  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst || !en || reload)
      cnt_q <= CW'(SETTLE_CYC);
    else if (cnt_q != '0)
      cnt_q <= cnt_q - 1'b1;
  end

  assign settled = en && (cnt_q == '0);

  assert_settle_drop_R3: assert property (@(posedge clk) disable iff (rst)
    !en |=> !settled);
endmodule

// File: rtl/adc_conv_engine.sv
`timescale 1ns/1ps
module adc_conv_engine
  import adc_seq_pkg::*;
#(
  parameter int CH_W   = 3,
  parameter int SCAN_N = 4,
  localparam int IDX_W = (SCAN_N > 1) ? $clog2(SCAN_N) : 1
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            active,
  input  logic            scan,
  input  trig_mode_e      tmode,
  input  logic            hw_trig,
  input  logic            settled,
  input  logic [CH_W-1:0] base_ch,
  input  logic            conv_done,
  output logic            conv_start_o,
  output logic [CH_W-1:0] conv_ch_o,
  output logic            res_valid_o,
  output logic            res_discard_o,
  output logic [CH_W-1:0] res_ch_o,
  output logic            busy,
  output logic            timer_reload
);
  eng_state_e      state_q;
  logic [IDX_W-1:0] idx_q;
  logic            first_q, early_q, prev_act_q;
  logic            is_wait, is_nowait, is_sw, go_now, wait_trig;
  logic [CH_W-1:0] next_ch;

  assign is_wait   = (tmode == TRIG_HW_WAIT);
  assign is_nowait = (tmode == TRIG_HW_NOWAIT);
  assign is_sw     = !is_wait && !is_nowait;
  assign go_now    = is_sw || (is_nowait && hw_trig);
  assign wait_trig = is_wait && hw_trig;
  assign next_ch   = scan ? base_ch + CH_W'(idx_q) : base_ch;
  assign busy      = (state_q != ENG_IDLE);
  assign timer_reload = active && (state_q == ENG_IDLE) && wait_trig;

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q       <= ENG_IDLE;
      idx_q         <= '0;
      first_q       <= 1'b1;
      early_q       <= 1'b0;
      prev_act_q    <= 1'b0;
      conv_start_o  <= 1'b0;
      conv_ch_o     <= '0;
      res_valid_o   <= 1'b0;
      res_discard_o <= 1'b0;
      res_ch_o      <= '0;
    end else begin
      conv_start_o <= 1'b0;
      res_valid_o  <= 1'b0;
      prev_act_q   <= active;
      if (active && !prev_act_q)
        early_q <= !settled;
      if (!active) begin
        state_q <= ENG_IDLE;
        idx_q   <= '0;
        first_q <= 1'b1;
      end else begin
        unique case (state_q)
          ENG_IDLE: begin
            if (go_now) begin
              state_q      <= ENG_BUSY;
              conv_start_o <= 1'b1;
              conv_ch_o    <= next_ch;
            end else if (wait_trig) begin
              state_q <= ENG_STAB;
            end
          end
          ENG_STAB: begin
            if (settled) begin
              state_q      <= ENG_BUSY;
              conv_start_o <= 1'b1;
              conv_ch_o    <= next_ch;
            end
          end
          ENG_BUSY: begin
            if (conv_done) begin
              state_q       <= ENG_IDLE;
              res_valid_o   <= 1'b1;
              res_ch_o      <= conv_ch_o;
              res_discard_o <= first_q && early_q && !is_wait;
              first_q       <= 1'b0;
              if (scan)
                idx_q <= (idx_q == IDX_W'(SCAN_N - 1)) ? '0 : idx_q + 1'b1;
            end
          end
          default: state_q <= ENG_IDLE;
        endcase
      end
    end
  end

  assert_start_pulse_R12: assert property (@(posedge clk) disable iff (rst)
    conv_start_o |=> !conv_start_o);
  assert_result_after_done_R5: assert property (@(posedge clk) disable iff (rst)
    res_valid_o |-> $past(conv_done));
  assert_no_start_stopped_R11: assert property (@(posedge clk) disable iff (rst)
    !active |=> !conv_start_o);
  assert_wait_settle_R9: assert property (@(posedge clk) disable iff (rst)
    (state_q == ENG_STAB && !settled) |=> !conv_start_o);
endmodule

// File: rtl/adc_seq_ctrl.sv
`timescale 1ns/1ps
module adc_seq_ctrl
  import adc_seq_pkg::*;
#(
  parameter int CYC_PER_US = 8,
  parameter int SETTLE_US  = 1,
  parameter int CH_W       = 3,
  parameter int SCAN_N     = 4,
  localparam int SETTLE_CYC = CYC_PER_US * SETTLE_US
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            wr_en,
  input  logic            wr_bit,
  input  logic [2:0]      wr_idx,
  input  logic            wr_val,
  input  logic [7:0]      wr_data,
  output logic [7:0]      rd_data,
  input  logic            base_wr,
  input  logic [CH_W-1:0] base_data,
  input  logic [1:0]      trig_mode,
  input  logic            hw_trig,
  output logic            cmp_ready,
  output logic [4:0]      ctime_sel,
  output logic            conv_start,
  output logic [CH_W-1:0] conv_ch,
  input  logic            conv_done,
  output logic            res_valid,
  output logic            res_discard,
  output logic [CH_W-1:0] res_ch
);
  logic [MODE_W-1:0] mode_q;
  logic [CH_W-1:0]   base_q;
  logic              busy, reload, stat;
  trig_mode_e        tmode;

  assign tmode     = trig_mode_e'(trig_mode);
  assign ctime_sel = mode_q[CTIME_HI:CTIME_LO];

  always_ff @(posedge clk) begin
    if (rst)          base_q <= '0;
    else if (base_wr) base_q <= base_data;
  end

  adc_mode_reg #(.REG_W(MODE_W)) u_reg (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_bit(wr_bit), .wr_idx(wr_idx),
    .wr_val(wr_val), .wr_data(wr_data), .mode_q(mode_q)
  );

  adc_settle_timer #(.SETTLE_CYC(SETTLE_CYC)) u_timer (
    .clk(clk), .rst(rst), .en(mode_q[BIT_CMP_EN]), .reload(reload),
    .settled(cmp_ready)
  );

  adc_conv_engine #(.CH_W(CH_W), .SCAN_N(SCAN_N)) u_eng (
    .clk(clk), .rst(rst), .active(mode_q[BIT_RUN]), .scan(mode_q[BIT_SCAN]),
    .tmode(tmode), .hw_trig(hw_trig), .settled(cmp_ready), .base_ch(base_q),
    .conv_done(conv_done), .conv_start_o(conv_start), .conv_ch_o(conv_ch),
    .res_valid_o(res_valid), .res_discard_o(res_discard), .res_ch_o(res_ch),
    .busy(busy), .timer_reload(reload)
  );

  always_comb begin
    unique case (tmode)
      TRIG_HW_WAIT:   stat = busy;
      TRIG_HW_NOWAIT: stat = mode_q[BIT_RUN];
      default:        stat = mode_q[BIT_RUN] | busy;
    endcase
    rd_data = {stat, mode_q[BIT_RUN-1:0]};
  end
endmodule

// File: tb/tb_adc_seq_ctrl.sv
`timescale 1ns/1ps
module tb_adc_seq_ctrl;
  localparam int CLK_PERIOD = 10;
  localparam int SETTLE     = 8;
  localparam int CH_W       = 3;
  localparam int LAT        = 4;

  typedef struct packed { logic [CH_W-1:0] ch; logic disc; } exp_t;

  logic clk = 1'b0, rst = 1'b1;
  logic wr_en = 0, wr_bit = 0, wr_val = 0, base_wr = 0, hw_trig = 0, conv_done = 0;
  logic [2:0] wr_idx = 0;
  logic [7:0] wr_data = 0;
  logic [CH_W-1:0] base_data = 0;
  logic [1:0] trig_mode = 2'b00;
  logic [7:0] rd_data;
  logic cmp_ready, conv_start, res_valid, res_discard;
  logic [4:0] ctime_sel;
  logic [CH_W-1:0] conv_ch, res_ch;

  int vectors = 0, miscompares = 0, results = 0, lat_cnt = 0;
  bit finished = 0;
  exp_t sb[$];

  always #(CLK_PERIOD/2) clk = ~clk;

  adc_seq_ctrl #(.CYC_PER_US(SETTLE), .SETTLE_US(1), .CH_W(CH_W), .SCAN_N(4)) dut (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_bit(wr_bit), .wr_idx(wr_idx),
    .wr_val(wr_val), .wr_data(wr_data), .rd_data(rd_data), .base_wr(base_wr),
    .base_data(base_data), .trig_mode(trig_mode), .hw_trig(hw_trig),
    .cmp_ready(cmp_ready), .ctime_sel(ctime_sel), .conv_start(conv_start),
    .conv_ch(conv_ch), .conv_done(conv_done), .res_valid(res_valid),
    .res_discard(res_discard), .res_ch(res_ch)
  );

  // Converter core model: done LAT cycles after each start
  always @(negedge clk) begin
    conv_done = 1'b0;
    if (lat_cnt != 0) begin
      lat_cnt--;
      if (lat_cnt == 0) conv_done = 1'b1;
    end
    if (conv_start) lat_cnt = LAT - 1;
  end

  task automatic chk(input string req, input int act, input int exp);
    vectors++;
    if (act != exp) begin
      miscompares++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // Scoreboard monitor
  always @(negedge clk) begin
    if (!rst && res_valid) begin
      results++;
      if (sb.size() == 0) begin
        vectors++; miscompares++;
        $display("FAIL R11 unexpected result: actual ch %0d expected none", res_ch);
      end else begin
        exp_t e;
        e = sb.pop_front();
        chk("R5/R6/R7 result channel", int'(res_ch), int'(e.ch));
        chk("R4 discard flag", int'(res_discard), int'(e.disc));
      end
    end
  end

  task automatic wr_byte(input logic [7:0] d);
    @(negedge clk); wr_en = 1; wr_bit = 0; wr_data = d;
    @(negedge clk); wr_en = 0;
  endtask

  task automatic wr_one(input logic [2:0] idx, input logic v);
    @(negedge clk); wr_en = 1; wr_bit = 1; wr_idx = idx; wr_val = v;
    @(negedge clk); wr_en = 0; wr_bit = 0;
  endtask

  task automatic pulse_trig();
    @(negedge clk); hw_trig = 1;
    @(negedge clk); hw_trig = 0;
  endtask

  task automatic push(input int ch, input bit d);
    exp_t e;
    e.ch = CH_W'(ch); e.disc = d;
    sb.push_back(e);
  endtask

  task automatic drain();
    while (sb.size() != 0) begin @(posedge clk); #1; end
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic count_starts(input int n, output int s);
    s = 0;
    for (int i = 0; i < n; i++) begin @(negedge clk); if (conv_start) s++; end
  endtask

  task automatic report();
    if (!finished) begin
      finished = 1;
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    vectors++; miscompares++;
    $display("FAIL watchdog: actual timeout expected completion");
    report();
  end

  initial begin
    int n, s, r0;
    repeat (4) @(negedge clk);
    rst = 0;
    // R1 reset state
    chk("R1 rd_data", int'(rd_data), 0);
    chk("R1 cmp_ready", int'(cmp_ready), 0);
    count_starts(6, s);
    chk("R1 no start", s, 0);

    // R2 byte and bit writes
    wr_byte(8'h5C);
    chk("R2 byte write", int'(rd_data), 'h5C);
    chk("R2 ctime_sel", int'(ctime_sel), 'h17);
    wr_one(3'd3, 1'b0);
    chk("R2 bit clear", int'(rd_data), 'h54);
    wr_one(3'd1, 1'b1);
    chk("R2 bit set", int'(rd_data), 'h56);
    wr_byte(8'h00);

    @(negedge clk); base_wr = 1; base_data = 3'd6;
    @(negedge clk); base_wr = 0;

    // R3 settle timing
    wr_byte(8'h01);
    idle(SETTLE - 1);
    chk("R3 not yet settled", int'(cmp_ready), 0);
    idle(1);
    chk("R3 settled", int'(cmp_ready), 1);
    wr_one(3'd0, 1'b0);
    chk("R3 drop on disable", int'(cmp_ready), 0);

    // R4/R5/R6 early start in software single mode
    wr_byte(8'h01);
    push(6, 1); push(6, 0); push(6, 0);
    wr_byte(8'h81);
    drain();
    wr_byte(8'h01);
    idle(1);
    chk("R8 stopped status", int'(rd_data[7]), 0);
    r0 = results;
    idle(12);
    chk("R11 no result after stop", results - r0, 0);

    // R7/R8 scan, late start
    idle(SETTLE + 2);
    push(6, 0); push(7, 0); push(0, 0); push(1, 0); push(6, 0);
    wr_byte(8'h83);
    chk("R8 running status", int'(rd_data[7]), 1);
    drain();
    wr_byte(8'h03);
    idle(1);
    chk("R8 stop status", int'(rd_data[7]), 0);
    idle(12);
    push(6, 0); push(7, 0);
    wr_byte(8'h83);
    drain();
    wr_byte(8'h01);
    idle(12);

    // R9 hardware wait mode
    trig_mode = 2'b01;
    wr_byte(8'h81);
    count_starts(10, s);
    chk("R9 no start without trigger", s, 0);
    chk("R9 standby status", int'(rd_data[7]), 0);
    push(6, 0);
    pulse_trig();
    chk("R9 waiting status", int'(rd_data[7]), 1);
    n = 1;
    while (!conv_start) begin @(negedge clk); n++; end
    chk("R9 start delay", n, SETTLE + 2);
    drain();
    chk("R9 status after result", int'(rd_data[7]), 0);
    wr_byte(8'h01);
    idle(4);

    // R10 hardware no-wait mode
    trig_mode = 2'b10;
    wr_byte(8'h81);
    chk("R10 status is written value", int'(rd_data[7]), 1);
    push(6, 0);
    pulse_trig();
    chk("R10 immediate start", int'(conv_start), 1);
    @(negedge clk);
    chk("R12 start one cycle", int'(conv_start), 0);
    drain();
    chk("R10 status after result", int'(rd_data[7]), 1);
    wr_one(3'd7, 1'b0);
    chk("R10 status cleared", int'(rd_data[7]), 0);
    idle(4);

    // R11 abort in flight
    trig_mode = 2'b00;
    wr_byte(8'h81);
    while (!conv_start) @(negedge clk);
    r0 = results;
    wr_byte(8'h01);
    count_starts(12, s);
    chk("R11 no start after abort", s, 0);
    chk("R11 no result after abort", results - r0, 0);

    chk("R5 scoreboard empty", sb.size(), 0);
    report();
  end
endmodule